// File: doc/BRIEF.md
# Request/Acknowledge Handshake Monitor

This block watches one request line and one acknowledge line and checks that the pair follows a simple single-outstanding handshake. A request opens when the request line is sampled rising; it closes when the acknowledge line is sampled rising, or when no acknowledge has come by the upper latency bound. The monitor never drives the handshake. It only reports what it sees.

Five kinds of misuse are recognised:
- a request issued while one is still open;
- an acknowledge when no request has been issued since reset or since the last timeout;
- an extra acknowledge after a request has already been answered;
- an acknowledge that comes sooner than the lower latency bound;
- a request left unanswered up to the upper bound.

Each kind has its own sticky status bit, which only reset clears. A shared error line pulses for one cycle each time a violation is seen.

Latency is counted in rising clock edges. It runs from the edge at which the request rise is sampled to the edge at which the acknowledge rise is sampled. The window is set by the parameters `LAT_MIN` and `LAT_MAX`, where 1 <= `LAT_MIN` <= `LAT_MAX`.

Top module: `hs_monitor`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released with both lines low, all five status outputs and `err_pulse` are 0.
- R2: A request is a sampled 0-to-1 change of `req`, and an acknowledge is a sampled 0-to-1 change of `ack`. An acknowledge whose latency L satisfies `LAT_MIN` <= L <= `LAT_MAX` closes the request and raises no flag.
- R3: A request rise sampled while a request is open, with no acknowledge rise at the same edge and latency below `LAT_MAX`, sets `dup_req`. The open request keeps its original timing.
- R4: An acknowledge rise while no request is open, and none has been answered since the last reset, new request or timeout, sets `orphan_ack`.
- R5: An acknowledge rise while no request is open, but after the last request was answered, sets `dup_ack`.
- R6: An acknowledge rise with latency L < `LAT_MIN` sets `early_ack` and closes the request.
- R7: If an open request reaches latency `LAT_MAX` with no acknowledge rise at that edge, `timeout` is set and the request is dropped. A later acknowledge then counts as orphan (R4).
- R8: Holding `ack` or `req` high creates no further events. Only a fresh rise counts.
- R9: An acknowledge rise and a new request rise at the same edge close the old request and open the new one, with no violation.
- R10: Each status bit, once set, stays set until reset.
- R11: `err_pulse` is high for exactly one cycle, the cycle after each edge at which one or more violations are detected. It is a clean single cycle that lines up with the status bits getting set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset, disables all checking |
| req | input | 1 | Monitored request line |
| ack | input | 1 | Monitored acknowledge line |
| dup_req | output | 1 | Sticky: request issued while one was open |
| orphan_ack | output | 1 | Sticky: acknowledge with nothing requested |
| dup_ack | output | 1 | Sticky: second acknowledge for an answered request |
| early_ack | output | 1 | Sticky: acknowledge below the latency window |
| timeout | output | 1 | Sticky: no acknowledge by the latency limit |
| err_pulse | output | 1 | One-cycle pulse per violating edge |

## Verification
Some properties are checked by assertions on every cycle:
- the status bits never clear;
- every new status bit comes with a pulse;
- the latency counter stays inside its window while a request is open;
- a request is always dropped at the limit.

The bench covers what only whole sequences can show. It sweeps acknowledge latency across and past the window, and sweeps the position of a second request up to and onto the timeout edge. It also drives repeated orphan acknowledges, a held acknowledge level, and a same-edge handoff. For each sequence it compares the final flags and the number of error pulses against values worked out from the latency bounds.

// File: rtl/hs_monitor.sv
module hs_monitor #(
  parameter int LAT_MIN = 1,
  parameter int LAT_MAX = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic ack,
  output logic dup_req,
  output logic orphan_ack,
  output logic dup_ack,
  output logic early_ack,
  output logic timeout,
  output logic err_pulse
);

  localparam int CW = $clog2(LAT_MAX + 1);
  localparam logic [CW-1:0] LMAX = CW'(LAT_MAX);
  localparam logic [CW-1:0] LMIN = CW'(LAT_MIN);

  logic          req_q, ack_q;
  logic          open_q, answered_q;
  logic [CW-1:0] lat_q;
  logic [4:0]    flags_q;
  logic          pulse_q;

  logic          req_rise, ack_rise;
  logic          v_dup_req, v_orphan, v_dup_ack, v_early, v_tmo;
  logic          open_n, answered_n;
  logic [CW-1:0] lat_n;
  logic [4:0]    hit;

  assign req_rise = req & ~req_q;
  assign ack_rise = ack & ~ack_q;
  assign v_tmo     = open_q && !ack_rise && (lat_q == LMAX);
  assign v_dup_req = open_q && req_rise && !ack_rise && (lat_q != LMAX);
  assign v_early   = open_q && ack_rise && (lat_q < LMIN);
  assign v_orphan  = !open_q && ack_rise && !answered_q;
  assign v_dup_ack = !open_q && ack_rise && answered_q;
  assign hit = {v_tmo, v_early, v_dup_ack, v_orphan, v_dup_req};

  always_comb begin
    open_n     = open_q;
    answered_n = answered_q;
    lat_n      = lat_q;
    if (open_q && ack_rise) begin
      open_n     = 1'b0;
      answered_n = 1'b1;
    end else if (v_tmo) begin
      open_n     = 1'b0;
      answered_n = 1'b0;
    end else if (open_q) begin
      lat_n = lat_q + 1'b1;
    end
    if (req_rise && !v_dup_req) begin
      open_n     = 1'b1;
      answered_n = 1'b0;
      lat_n      = CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q      <= 1'b0;
      ack_q      <= 1'b0;
      open_q     <= 1'b0;
      answered_q <= 1'b0;
      lat_q      <= '0;
      flags_q    <= '0;
      pulse_q    <= 1'b0;
    end else begin
      req_q      <= req;
      ack_q      <= ack;
      open_q     <= open_n;
      answered_q <= answered_n;
      lat_q      <= lat_n;
      flags_q    <= flags_q | hit;
      pulse_q    <= |hit;
    end
  end

  assign dup_req    = flags_q[0];
  assign orphan_ack = flags_q[1];
  assign dup_ack    = flags_q[2];
  assign early_ack  = flags_q[3];
  assign timeout    = flags_q[4];
  assign err_pulse  = pulse_q;

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & $past(flags_q)) == $past(flags_q));

  p_pulse_on_new_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != $past(flags_q)) |-> err_pulse);

  p_lat_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (lat_q >= CW'(1) && lat_q <= LMAX));

  p_drop_at_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && lat_q == LMAX && !ack_rise && !req_rise) |=> !open_q);

  p_dup_req_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && req_rise && !ack_rise && lat_q != LMAX) |=> dup_req && err_pulse);

  p_orphan_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !answered_q && ack_rise) |=> orphan_ack && err_pulse);

  p_ack_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && ack_rise && !req_rise) |=> !open_q && answered_q);

endmodule

// File: tb/hs_monitor_tb.sv
`timescale 1ns/1ps
module hs_monitor_tb;
  localparam int MN = 2;
  localparam int MX = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic ack = 1'b0;
  logic dup_req, orphan_ack, dup_ack, early_ack, timeout, err_pulse;

  int tests = 0;
  int fails = 0;
  int pulses = 0;

  always #2 clk = ~clk;

  hs_monitor #(.LAT_MIN(MN), .LAT_MAX(MX)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ack(ack),
    .dup_req(dup_req), .orphan_ack(orphan_ack), .dup_ack(dup_ack),
    .early_ack(early_ack), .timeout(timeout), .err_pulse(err_pulse)
  );

  always @(negedge clk) if (rst_n && err_pulse) pulses++;

  // flag vector order: {timeout, early_ack, dup_ack, orphan_ack, dup_req}
  task automatic check(input string tag, input logic [4:0] exp_f, input int exp_p);
    logic [4:0] got;
    got = {timeout, early_ack, dup_ack, orphan_ack, dup_req};
    tests++;
    if (got !== exp_f || pulses != exp_p) begin
      fails++;
      $display("FAIL %s: flags=%b pulses=%0d expected flags=%b pulses=%0d",
               tag, got, pulses, exp_f, exp_p);
    end
  endtask

  task automatic drive(input logic r, input logic a);
    @(negedge clk);
    req = r;
    ack = a;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    tests++;
    if ({timeout, early_ack, dup_ack, orphan_ack, dup_req, err_pulse} !== 6'b0) begin
      fails++;
      $display("FAIL R1: outputs in reset=%b expected 000000",
               {timeout, early_ack, dup_ack, orphan_ack, dup_req, err_pulse});
    end
    rst_n = 1'b1;
    pulses = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    idle(2);
    check("R1 idle after reset", 5'b0, 0);

    // R2 R6 R7: latency sweep
    for (int k = 1; k <= MX + 2; k++) begin
      logic [4:0] ef;
      int ep;
      do_reset();
      drive(1'b1, 1'b0);
      for (int i = 1; i < k; i++) drive(1'b0, 1'b0);
      drive(1'b0, 1'b1);
      idle(MX + 3);
      if (k < MN)       begin ef = 5'b01000; ep = 1; end
      else if (k <= MX) begin ef = 5'b00000; ep = 0; end
      else              begin ef = 5'b10010; ep = 2; end
      check($sformatf("R2/R6/R7 latency %0d", k), ef, ep);
    end

    // R3 R7: second request at edge j after the first, no acknowledge
    for (int j = 2; j <= MX; j++) begin
      do_reset();
      drive(1'b1, 1'b0);
      for (int i = 1; i < j; i++) drive(1'b0, 1'b0);
      drive(1'b1, 1'b0);
      idle(MX + 3);
      if (j < MX) check($sformatf("R3 second req at %0d", j), 5'b10001, 2);
      else        check($sformatf("R7 req on timeout edge %0d", j), 5'b10000, 2);
    end

    // R7: request on timeout edge is a fresh request, answered in window
    do_reset();
    drive(1'b1, 1'b0);
    idle(MX - 1);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    idle(MX + 2);
    check("R7 timeout then fresh request answered", 5'b10000, 1);

    // R4: n orphan acknowledges
    for (int n = 1; n <= 3; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) begin
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
      end
      idle(2);
      check($sformatf("R4 %0d orphan acks", n), 5'b00010, n);
    end

    // R5: second acknowledge after a valid one
    do_reset();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    idle(3);
    check("R5 duplicate ack", 5'b00100, 1);

    // R8: acknowledge held high is one event
    do_reset();
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b1);
    idle(MX + 2);
    check("R8 held levels", 5'b0, 0);

    // R9: same-edge handoff, then second request answered in window
    do_reset();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b1);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    idle(MX + 2);
    check("R9 same-edge handoff", 5'b0, 0);

    // R10 R11: violation then clean transaction keeps flag, no new pulse
    do_reset();
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b1);
    idle(2);
    drive(1'b1, 1'b0);
    drive(1'b0, 1'b0);
    drive(1'b0, 1'b1);
    idle(MX + 2);
    check("R10 R11 sticky after clean transaction", 5'b00001, 1);

    do_reset();
    idle(1);
    check("R1 R10 reset clears flags", 5'b0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule